// File: doc/BRIEF.md
# Voltage-Frequency Working-Point Ramp Sequencer

This block moves one clock domain from its present operating point to a requested one while the domain keeps running. The operating points form an ordered ladder, from the slowest and lowest-voltage rung at index 0 up to the fastest rung. The block holds two separate rung indices: one selects the supply voltage and the other selects the clock frequency. It changes them one rung at a time, paced by a programmable step interval. Neither the clock nor the domain is held off at any point during a ramp.

The two indices move in an order that keeps the domain safe. When the target is higher, the voltage index climbs one rung and the frequency index follows it one interval later. When the target is lower, the frequency index drops one rung and the voltage index follows it one interval later. The target may change at any moment. A voltage/frequency pair that has already started is always completed before the block heads for the new target. Targets above the top rung are treated as the top rung. The codes drive an external regulator and clock generator. A policy outside the block picks the target.

Top module: `wpt_ramp_seq`

## Requirements
- R1: While reset is asserted, and after it is released with target 0, both codes are 0 and busy is low.
- R2: A target index above NUM_POINTS-1 is treated as NUM_POINTS-1 (319 by default). The codes never exceed that value.
- R3: In every cycle the frequency code is less than or equal to the voltage code.
- R4: The codes change only on a step tick. A step tick occurs once every STEP_CYCLES clock cycles. At each tick at most one of the two codes changes, and it changes by exactly one.
- R5: When the target is above the codes, the voltage code rises first. The frequency code then rises to meet it on the next tick, and the voltage code does not change on that tick.
- R6: When the target is below the codes, the frequency code falls first. The voltage code then falls to meet it on the next tick, and the frequency code does not change on that tick.
- R7: If the target reverses while the two codes differ, the next change completes the pending pair. Only after that do the codes move toward the new target.
- R8: Busy is high exactly when either code differs from the clamped target. It follows a target change in the same cycle.
- R9: When busy is low and the target does not change, neither code changes.
- R10: A ramp from rung 0 to rung 319 takes 638 step ticks, which is between 637*STEP_CYCLES+1 and 638*STEP_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the controlled domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tgt_idx_i | input | 9 | Requested working-point index (clamped to 319) |
| v_code_o | output | 9 | Voltage rung index sent to the regulator |
| f_code_o | output | 9 | Frequency rung index sent to the clock generator |
| busy_o | output | 1 | High while either code is away from the target |

## Verification
The bench keeps the default ladder of 320 rungs, so the 9-bit target input can carry values from 320 to 511. This exercises the clamp from several unclamped values. It sets STEP_CYCLES to 4 instead of the default 172. With that setting a full bottom-to-top ramp of 638 ticks takes about 2,600 cycles, so the complete ladder, a mid-pair reversal and the settled hold all fit in one short run. The short interval also means that timer phases and target changes fall at many different positions relative to the tick.

// File: rtl/wpt_ramp_pkg.sv
package wpt_ramp_pkg;

  // Position inside a voltage/frequency pair of moves.
  typedef enum logic [1:0] {
    PH_PAIRED = 2'd0,   // both indices on the same rung
    PH_UP_LAG = 2'd1,   // voltage already one rung above, frequency pending
    PH_DN_LAG = 2'd2    // frequency already one rung below, voltage pending
  } ramp_phase_e;

endpackage

// File: rtl/wpt_rst_sync.sv
module wpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/wpt_step_timer.sv
module wpt_step_timer #(
  parameter int STEP_CYCLES = 172
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  // R4: the interval counter never leaves its range
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/wpt_tgt_clamp.sv
module wpt_tgt_clamp #(
  parameter int IDX_W   = 9,
  parameter int MAX_IDX = 319
) (
  input  logic [IDX_W-1:0] tgt_i,
  output logic [IDX_W-1:0] tgt_o
);

  localparam logic [IDX_W-1:0] CEIL = IDX_W'(MAX_IDX);

  always_comb begin
    tgt_o = (tgt_i > CEIL) ? CEIL : tgt_i;
  end

endmodule

// File: rtl/wpt_ramp_core.sv
module wpt_ramp_core
  import wpt_ramp_pkg::*;
#(
  parameter int IDX_W   = 9,
  parameter int MAX_IDX = 319
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [IDX_W-1:0] tgt_i,
  output logic [IDX_W-1:0] v_o,
  output logic [IDX_W-1:0] f_o,
  output logic             busy_o
);

  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] v_q, v_d, f_q, f_d;
  ramp_phase_e      ph_q, ph_d;

  // Next-state: a pair always starts from PH_PAIRED and returns there
  always_comb begin
    v_d  = v_q;
    f_d  = f_q;
    ph_d = ph_q;
    unique case (ph_q)
      PH_PAIRED: begin
        if (tgt_i > v_q) begin
          v_d  = v_q + ONE;
          ph_d = PH_UP_LAG;
        end else if (tgt_i < f_q) begin
          f_d  = f_q - ONE;
          ph_d = PH_DN_LAG;
        end
      end
      PH_UP_LAG: begin
        f_d  = f_q + ONE;
        ph_d = PH_PAIRED;
      end
      PH_DN_LAG: begin
        v_d  = v_q - ONE;
        ph_d = PH_PAIRED;
      end
      default: ph_d = PH_PAIRED;
    endcase
  end

  // Registers, enabled by the step tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      f_q  <= '0;
      ph_q <= PH_PAIRED;
    end else if (tick_i) begin
      v_q  <= v_d;
      f_q  <= f_d;
      ph_q <= ph_d;
    end
  end

  assign v_o    = v_q;
  assign f_o    = f_q;
  assign busy_o = (v_q != tgt_i) || (f_q != tgt_i);

  // R3: frequency never above voltage
  p_fv_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f_q <= v_q);

  // R2: codes stay on the ladder
  p_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_q <= IDX_W'(MAX_IDX));

  // R4: nothing moves without a tick
  p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> ($stable(v_q) && $stable(f_q)));

  // R4: at most one index moves per edge
  p_single_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({v_q != $past(v_q), f_q != $past(f_q)}) <= 1);

  // R5: frequency rises only onto an already raised voltage
  p_up_volt_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (f_q > $past(f_q)) |-> ((f_q == v_q) && $stable(v_q)));

  // R6: voltage falls only onto an already lowered frequency
  p_dn_freq_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q < $past(v_q)) |-> ((v_q == f_q) && $stable(f_q)));

  // R9: settled with a steady target means no motion
  p_settled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $stable(tgt_i)) |=> ($stable(v_q) && $stable(f_q)));

endmodule

// File: rtl/wpt_ramp_seq.sv
module wpt_ramp_seq #(
  parameter int NUM_POINTS  = 320,
  parameter int STEP_CYCLES = 172,
  parameter int IDX_W       = $clog2(NUM_POINTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] tgt_idx_i,
  output logic [IDX_W-1:0] v_code_o,
  output logic [IDX_W-1:0] f_code_o,
  output logic             busy_o
);

  localparam int MAX_IDX = NUM_POINTS - 1;

  logic             rst_int_n;
  logic             step_tick;
  logic [IDX_W-1:0] tgt_clamped;

  wpt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  wpt_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (step_tick)
  );

  wpt_tgt_clamp #(.IDX_W(IDX_W), .MAX_IDX(MAX_IDX)) u_clamp (
    .tgt_i (tgt_idx_i),
    .tgt_o (tgt_clamped)
  );

  wpt_ramp_core #(.IDX_W(IDX_W), .MAX_IDX(MAX_IDX)) u_core (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (step_tick),
    .tgt_i  (tgt_clamped),
    .v_o    (v_code_o),
    .f_o    (f_code_o),
    .busy_o (busy_o)
  );

endmodule

// File: tb/wpt_ramp_seq_tb_top.sv
module wpt_ramp_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPTS       = 320;
  localparam int STEP       = 4;
  localparam int W          = 9;
  localparam int TOP        = NPTS - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] tgt_idx;
  logic [W-1:0] v_code, f_code;
  logic         busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpt_ramp_seq #(.NUM_POINTS(NPTS), .STEP_CYCLES(STEP)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_idx_i (tgt_idx),
    .v_code_o  (v_code),
    .f_code_o  (f_code),
    .busy_o    (busy)
  );

  // Behavioural reference model
  int  m_v, m_f, m_ph, m_cnt;
  bit  m_s0, m_s1;

  function automatic int clamp_t(input int t);
    return (t > TOP) ? TOP : t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_cnt = 0; m_v = 0; m_f = 0; m_ph = 0;
    end else begin
      if (m_s1) begin
        if (m_cnt == STEP - 1) begin
          int t;
          m_cnt = 0;
          t = clamp_t(int'(tgt_idx));
          if (m_ph == 1) begin m_f = m_f + 1; m_ph = 0; end
          else if (m_ph == 2) begin m_v = m_v - 1; m_ph = 0; end
          else if (t > m_v) begin m_v = m_v + 1; m_ph = 1; end
          else if (t < m_f) begin m_f = m_f - 1; m_ph = 2; end
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      m_s1 = m_s0;
      m_s0 = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, a quarter period after the rising edge
  int p_v = 0, p_f = 0;
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      int mb;
      mb = ((m_v != clamp_t(int'(tgt_idx))) || (m_f != clamp_t(int'(tgt_idx)))) ? 1 : 0;
      check(int'(v_code) == m_v, "R4 voltage code", int'(v_code), m_v);
      check(int'(f_code) == m_f, "R4 frequency code", int'(f_code), m_f);
      check(int'(busy) == mb, "R8 busy", int'(busy), mb);
      check(f_code <= v_code, "R3 order", int'(f_code), int'(v_code));
      if (int'(f_code) > p_f)
        check((int'(f_code) == int'(v_code)) && (int'(v_code) == p_v),
              "R5 voltage leads up", int'(v_code), int'(f_code));
      if (int'(v_code) < p_v)
        check((int'(v_code) == int'(f_code)) && (int'(f_code) == p_f),
              "R6 frequency leads down", int'(f_code), int'(v_code));
      p_v = int'(v_code);
      p_f = int'(f_code);
    end
  end

  task automatic report();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic settle(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check(1'b0, "R8 settle timeout", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 1, 0);
    report();
  end

  initial begin
    int n;
    int ov, of;
    rst_n   = 1'b0;
    tgt_idx = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(v_code == 0 && f_code == 0 && !busy, "R1 reset state", int'(v_code), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(v_code == 0 && f_code == 0 && !busy, "R1 after release", int'(v_code), 0);

    // R5 ramp up
    tgt_idx = 9'd6;
    settle(200);
    check(v_code == 6 && f_code == 6, "R5 reached 6", int'(f_code), 6);

    // R9 settled hold
    repeat (3 * STEP) @(negedge clk);
    check(v_code == 6 && f_code == 6 && !busy, "R9 hold", int'(v_code), 6);

    // R6 ramp down
    tgt_idx = 9'd2;
    settle(200);
    check(v_code == 2 && f_code == 2, "R6 reached 2", int'(v_code), 2);

    // R7 reversal in the middle of an up pair
    tgt_idx = 9'd20;
    for (int i = 0; i < 50 && v_code == f_code; i++) @(negedge clk);
    check(int'(v_code) == int'(f_code) + 1, "R7 split upward", int'(v_code), int'(f_code) + 1);
    ov = int'(v_code); of = int'(f_code);
    tgt_idx = 9'd0;
    for (int i = 0; i < 50 && int'(v_code) == ov && int'(f_code) == of; i++) @(negedge clk);
    check(int'(f_code) == ov && int'(v_code) == ov, "R7 pair completed", int'(f_code), ov);
    ov = int'(v_code); of = int'(f_code);
    for (int i = 0; i < 50 && int'(v_code) == ov && int'(f_code) == of; i++) @(negedge clk);
    check(int'(f_code) == ov - 1 && int'(v_code) == ov, "R7 then heads down", int'(f_code), ov - 1);
    settle(200);
    check(v_code == 0 && f_code == 0, "R7 reached 0", int'(v_code), 0);

    // R10 full traversal time
    tgt_idx = 9'(TOP);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (!busy) break;
    end
    check(n >= 637 * STEP + 1 && n <= 638 * STEP, "R10 traversal cycles", n, 638 * STEP);
    check(int'(v_code) == TOP && int'(f_code) == TOP, "R10 at top", int'(v_code), TOP);

    // R2 clamp of out-of-range targets
    tgt_idx = 9'd500;
    @(negedge clk);
    check(!busy, "R2 clamped busy", int'(busy), 0);
    repeat (3 * STEP) @(negedge clk);
    check(int'(v_code) == TOP && int'(f_code) == TOP, "R2 no overshoot", int'(v_code), TOP);
    tgt_idx = 9'd300;
    settle(300);
    tgt_idx = 9'd511;
    settle(300);
    check(int'(v_code) == TOP && int'(f_code) == TOP, "R2 clamp from 511", int'(v_code), TOP);

    repeat (2) @(negedge clk);
    report();
  end

endmodule